// File: doc/BRIEF.md
# Layered AND/XOR Configurable Gate Array

The block is a feed-forward array of two-input gates. A configuration word, called the chromosome, sets the wiring and the function of every gate. The gates sit in layers. Each gate reads two signals from the layer just below it and computes either AND or XOR of them. The first layer reads the primary inputs. With the default parameters there are four full layers of 16 gates. After them come tapering layers of 8, 4, 2 and 1 gates, which makes 79 gates in total. The single gate in the top layer drives the output. Nothing feeds back, so the output is a bounded-depth combinational function of the inputs and the stored chromosome.

The chromosome sits in a register. It can be written in one cycle through a parallel word port, or shifted in one bit per cycle through a serial port. An external search process can therefore try candidate circuits one after another and see each result on the output without any extra latency.

Each gate owns a 9-bit gene. Gate g holds bits [9g+8 : 9g] of the chromosome. Gates are numbered layer by layer from the first layer upward, and from position 0 up within a layer. Inside a gene, bits [8:5] are the index of the first operand, bits [4:1] are the index of the second operand, and bit [0] is the function.

Top module: `cga_array`

## Requirements
- R1: An active-low asynchronous reset clears the whole chromosome to zero. In that state every gate is an AND of source 0 with itself, so the output equals `data_i[0]`.
- R2: A gate whose function bit is 0 outputs the AND of its two selected sources.
- R3: A gate whose function bit is 1 outputs the XOR of its two selected sources. In particular, an XOR of a source with itself gives 0.
- R4: Each gate's two operands are taken only from the layer directly below it. Layer-1 gates take theirs from `data_i`. The gene of gate g occupies chromosome bits [9g+8:9g], with the first-operand index in [8:5], the second-operand index in [4:1] and the function in [0].
- R5: In layer 1, an operand index at or above the input count (10) selects input (index mod 10).
- R6: In the tapering layers, an operand index at or above the size of the layer below selects source (index mod that size).
- R7: When `load_i` is high at a rising clock edge, the chromosome takes `word_i` at that edge. The output reflects the new configuration combinationally from then on.
- R8: When `shift_i` is high and `load_i` is low at a rising edge, the chromosome shifts down by one place and `bit_i` enters the top bit. After CHROM_W shifts, the first bit sent sits in bit 0.
- R9: When `load_i` and `shift_i` are high together, the parallel load wins.
- R10: When both `load_i` and `shift_i` are low, the chromosome holds its value.
- R11: `out_o` is the output of the single gate in the last layer, and it changes only when the inputs or the chromosome change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the chromosome register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Parallel chromosome load enable |
| word_i | input | CHROM_W (711) | Parallel chromosome word |
| shift_i | input | 1 | Serial chromosome shift enable |
| bit_i | input | 1 | Serial chromosome data bit |
| data_i | input | NUM_IN (10) | Primary inputs |
| out_o | output | 1 | Output of the final gate |

## Verification
The hardest cases to reach from the ports are the index-wrap paths in layer 1 and in the narrow tapering layers. A path only reaches the output if every gate above it happens to select it. Random chromosomes alone rarely expose a single wrong wrap. The stimulus therefore adds uniform chromosomes in which every gate uses the same out-of-range index. That forces the wrapped source to propagate straight up to the output. Every configuration, random or directed, is checked against all 1024 input patterns, and the expected value is computed by a layer-by-layer model in the bench.

// File: rtl/cga_pkg.sv
package cga_pkg;

  function automatic int lyr_size(int wide, int nwide, int l);
    return (l < nwide) ? wide : (wide >> (l - nwide + 1));
  endfunction

  function automatic int num_layers(int wide, int nwide);
    return nwide + $clog2(wide);
  endfunction

  function automatic int lyr_off(int wide, int nwide, int l);
    int s;
    s = 0;
    for (int k = 0; k < l; k++) s += lyr_size(wide, nwide, k);
    return s;
  endfunction

  function automatic int sel_bits(int nin, int wide);
    return $clog2((nin > wide) ? nin : wide);
  endfunction

  function automatic int chrom_bits(int nin, int wide, int nwide);
    return lyr_off(wide, nwide, num_layers(wide, nwide)) * (2 * sel_bits(nin, wide) + 1);
  endfunction

endpackage

// File: rtl/cga_cfg_reg.sv
module cga_cfg_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (load_i)  q_o <= word_i;
    else if (shift_i) q_o <= {bit_i, q_o[W-1:1]};
  end

  AST_LOAD_TAKES_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_o == $past(word_i)); // R7
  AST_SHIFT_BODY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> q_o[W-2:0] == $past(q_o[W-1:1])); // R8
  AST_SHIFT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> q_o[W-1] == $past(bit_i)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !load_i) |=> $stable(q_o)); // R10

endmodule

// File: rtl/cga_gate.sv
module cga_gate #(
  parameter int IN_W  = 16,
  parameter int SEL_W = 4
) (
  input  logic [IN_W-1:0]  src_i,
  input  logic [2*SEL_W:0] gene_i,
  output logic             y_o
);
  localparam int EXT = 1 << SEL_W;

  logic [EXT-1:0]   src_ext;
  logic [SEL_W-1:0] idx_a, idx_b;
  logic             op_a, op_b;

  // out-of-range indices fold back onto the source layer
  for (genvar k = 0; k < EXT; k++) begin : g_wrap
    assign src_ext[k] = src_i[k % IN_W];
  end

  assign idx_a = gene_i[2*SEL_W -: SEL_W];
  assign idx_b = gene_i[SEL_W:1];
  assign op_a  = src_ext[idx_a];
  assign op_b  = src_ext[idx_b];
  assign y_o   = gene_i[0] ? (op_a ^ op_b) : (op_a & op_b);

endmodule

// File: rtl/cga_layer.sv
module cga_layer #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16,
  parameter int SEL_W = 4
) (
  input  logic [IN_W-1:0]                src_i,
  input  logic [OUT_W*(2*SEL_W+1)-1:0]   genes_i,
  output logic [OUT_W-1:0]               y_o
);
  localparam int GENE_W = 2 * SEL_W + 1;

  for (genvar g = 0; g < OUT_W; g++) begin : g_gate
    cga_gate #(.IN_W(IN_W), .SEL_W(SEL_W)) u_gate (
      .src_i  (src_i),
      .gene_i (genes_i[g*GENE_W +: GENE_W]),
      .y_o    (y_o[g])
    );
  end

endmodule

// File: rtl/cga_array.sv
module cga_array #(
  parameter int NUM_IN   = 10,
  parameter int WIDE     = 16,
  parameter int NUM_WIDE = 4
) (
  input  logic                                                 clk_i,
  input  logic                                                 rst_ni,
  input  logic                                                 load_i,
  input  logic [cga_pkg::chrom_bits(NUM_IN, WIDE, NUM_WIDE)-1:0] word_i,
  input  logic                                                 shift_i,
  input  logic                                                 bit_i,
  input  logic [NUM_IN-1:0]                                    data_i,
  output logic                                                 out_o
);
  import cga_pkg::*;

  localparam int SEL_W   = sel_bits(NUM_IN, WIDE);
  localparam int GENE_W  = 2 * SEL_W + 1;
  localparam int LAYERS  = num_layers(WIDE, NUM_WIDE);
  localparam int GATES   = lyr_off(WIDE, NUM_WIDE, LAYERS);
  localparam int CHROM_W = GATES * GENE_W;

  logic [CHROM_W-1:0] chrom;
  logic [GATES-1:0]   node;

  cga_cfg_reg #(.W(CHROM_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .word_i  (word_i),
    .shift_i (shift_i),
    .bit_i   (bit_i),
    .q_o     (chrom)
  );

  for (genvar l = 0; l < LAYERS; l++) begin : g_layer
    localparam int SZ  = lyr_size(WIDE, NUM_WIDE, l);
    localparam int OFF = lyr_off(WIDE, NUM_WIDE, l);
    if (l == 0) begin : g_first
      cga_layer #(.IN_W(NUM_IN), .OUT_W(SZ), .SEL_W(SEL_W)) u_layer (
        .src_i   (data_i),
        .genes_i (chrom[OFF*GENE_W +: SZ*GENE_W]),
        .y_o     (node[OFF +: SZ])
      );
    end else begin : g_upper
      localparam int PSZ  = lyr_size(WIDE, NUM_WIDE, l - 1);
      localparam int POFF = lyr_off(WIDE, NUM_WIDE, l - 1);
      cga_layer #(.IN_W(PSZ), .OUT_W(SZ), .SEL_W(SEL_W)) u_layer (
        .src_i   (node[POFF +: PSZ]),
        .genes_i (chrom[OFF*GENE_W +: SZ*GENE_W]),
        .y_o     (node[OFF +: SZ])
      );
    end
  end

  assign out_o = node[GATES-1];

  AST_OUT_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(chrom) && $stable(data_i)) |-> $stable(out_o)); // R11

endmodule

// File: tb/cga_array_bench.sv
module cga_array_bench;
  localparam int NI = 10;
  localparam int CW = 711;
  localparam int NL = 8;
  localparam int SZ [NL] = '{16, 16, 16, 16, 8, 4, 2, 1};

  logic clk_i = 1'b0, rst_ni = 1'b0, load_i = 1'b0, shift_i = 1'b0, bit_i = 1'b0;
  logic [CW-1:0] word_i = '0;
  logic [NI-1:0] data_i = '0;
  logic out_o;
  int vectors = 0, miscompares = 0;

  always #5 clk_i = ~clk_i;

  cga_array u_cga_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .word_i(word_i),
    .shift_i(shift_i), .bit_i(bit_i), .data_i(data_i), .out_o(out_o)
  );

  function automatic logic model(input logic [CW-1:0] c, input logic [NI-1:0] d);
    logic cur [16];
    logic nxt [16];
    int g, prev;
    for (int i = 0; i < 16; i++) cur[i] = (i < NI) ? d[i] : 1'b0;
    prev = NI;
    g = 0;
    for (int l = 0; l < NL; l++) begin
      for (int j = 0; j < SZ[l]; j++) begin
        int sa, sb;
        logic a, b;
        sa = int'(c[g*9+5 +: 4]) % prev;
        sb = int'(c[g*9+1 +: 4]) % prev;
        a = cur[sa];
        b = cur[sb];
        nxt[j] = c[g*9] ? (a ^ b) : (a & b);
        g++;
      end
      for (int j = 0; j < SZ[l]; j++) cur[j] = nxt[j];
      prev = SZ[l];
    end
    return cur[0];
  endfunction

  function automatic logic [CW-1:0] uniform(input int sa, input int sb, input logic f);
    logic [CW-1:0] c;
    for (int g = 0; g < 79; g++) c[g*9 +: 9] = {4'(sa), 4'(sb), f};
    return c;
  endfunction

  function automatic logic [CW-1:0] rand_chrom();
    logic [CW-1:0] c;
    for (int i = 0; i < CW; i++) c[i] = 1'($urandom);
    return c;
  endfunction

  task automatic check(input string req, input logic exp);
    vectors++;
    if (out_o !== exp) begin
      miscompares++;
      $display("FAIL %s data=%0d out=%b expected=%b", req, data_i, out_o, exp);
    end
  endtask

  task automatic sweep(input string req, input logic [CW-1:0] c);
    for (int d = 0; d < (1 << NI); d++) begin
      data_i = NI'(d);
      #1;
      check(req, model(c, data_i));
    end
  endtask

  task automatic pload(input logic [CW-1:0] c);
    @(negedge clk_i);
    word_i = c; load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [CW-1:0] c;
    #23;
    // R1: cleared chromosome passes data_i[0]
    for (int d = 0; d < (1 << NI); d++) begin
      data_i = NI'(d);
      #1;
      check("R1 reset", data_i[0]);
    end
    rst_ni = 1'b1;

    // R5: index 15 wraps to input 5 in layer 1; R6: wraps to 7,3,1 higher up
    c = uniform(15, 15, 1'b0); pload(c); sweep("R5 R6 wrap idx15", c);
    c = uniform(12, 12, 1'b0); pload(c); sweep("R5 R6 wrap idx12", c);
    c = uniform(11, 3, 1'b0);  pload(c); sweep("R5 R2 and wrap", c);
    // R3: x^x is zero everywhere
    c = uniform(9, 9, 1'b1);   pload(c); sweep("R3 xor self", c);
    c = uniform(1, 0, 1'b1);   pload(c); sweep("R3 xor chain", c);
    c = uniform(6, 2, 1'b0);   pload(c); sweep("R2 and chain", c);

    // R4 R7 R11: random configurations, every input pattern
    for (int n = 0; n < 24; n++) begin
      c = rand_chrom(); pload(c); sweep("R4 R7 R11 random", c);
    end

    // R8: serial load, bit 0 sent first
    c = rand_chrom();
    @(negedge clk_i);
    word_i = ~c;
    for (int i = 0; i < CW; i++) begin
      bit_i = c[i]; shift_i = 1'b1;
      @(negedge clk_i);
    end
    shift_i = 1'b0;
    sweep("R8 serial", c);

    // R9: load beats shift
    c = rand_chrom();
    @(negedge clk_i);
    word_i = c; load_i = 1'b1; shift_i = 1'b1; bit_i = ~c[CW-1];
    @(negedge clk_i);
    load_i = 1'b0; shift_i = 1'b0;
    sweep("R9 priority", c);

    // R10: idle cycles with changing word and bit leave configuration intact
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      word_i = rand_chrom(); bit_i = ~bit_i;
    end
    sweep("R10 hold", c);

    summary();
    $finish;
  end

endmodule